// File: doc/BRIEF.md
# Round-Robin Multithreaded Three-Stage Integer Core

This block is a small in-order integer core that interleaves several independent hardware threads. Each cycle it fetches one instruction from the next thread in a fixed rotation. Because of this, consecutive pipeline slots never hold two instructions from the same thread. The core therefore has no forwarding paths and no stall logic, and it never holds an instruction back. Each thread has its own program counter. All threads share one register memory, which is split into one 32-entry bank per thread and addressed by thread number together with the register number.

The pipeline has three stages:
- **Fetch/decode:** the selected thread's program counter goes out on the instruction port, and the returned word is decoded.
- **Execute:** registers are read, the ALU or multiplier runs, the data memory is accessed and the branch is resolved. The thread's program counter is updated at the end of this stage.
- **Writeback:** the result is written into the thread's register bank.

The thread number travels with every instruction so that both updates reach the right thread. Instruction and data memories sit outside the block and answer combinationally, so the fixed latency is zero wait cycles.

The thread selector is the only state machine. It has one state per thread, `SLOT_0` to `SLOT_N-1`. Each cycle it takes the transition `SLOT_k -> SLOT_k+1`, and from the last slot it takes the wrap transition `SLOT_N-1 -> SLOT_0`. Reset forces it to `SLOT_0`. The thread count may be lowered to two. Program counters are written in the execute stage, so a thread's branch is resolved before its next turn. Registers are written one stage later, before the thread's next register read.

Top module: `mt_core`

## Requirements
- R1: `fetch_tid` takes the values 0, 1, ..., NUM_THREADS-1 in order, one per cycle, and wraps to 0. It is 0 in the first cycle after reset.
- R2: While reset is held, `fetch_tid` is 0, `imem_addr` is RESET_PC and `dmem_we` is 0. Every thread's first fetch is at RESET_PC, and every register reads 0 until written.
- R3: Unless a branch is taken, each thread's next fetch address is its previous one plus 4. Every fetch address is word aligned.
- R4: Instruction fields:
  - opcode is bits [31:26]; rs is [25:21]; rt is [20:16]; rd is [15:11]; imm is [15:0], sign-extended.
  - Opcodes 1 ADD, 2 SUB, 3 AND, 4 OR and 5 XOR write rd = rs op rt.
  - Opcode 6 ADDI writes rt = rs + imm.
  - Every opcode not listed in R4 to R8, including 0, does nothing.
- R5: Opcode 9 BEQZ sets the thread's next fetch to pc+4+imm*4 when rs is zero, and to pc+4 otherwise. The instruction after the branch is not executed when the branch is taken; there is no delay slot.
- R6: Opcode 7 LW writes rt = mem[rs+imm]. Opcode 8 SW raises `dmem_we` for one cycle with `dmem_addr` = rs+imm and `dmem_wdata` = rt. No other instruction raises `dmem_we`. Addresses are byte addresses.
- R7: Opcode 10 writes the low 32 bits of the unsigned 64-bit product rs*rt to rd. Opcode 11 writes the high 32 bits.
- R8: A register write by one thread is visible only to that thread. Opcode 12 writes the thread's own number into rd.
- R9: Register 0 of every thread reads as 0, and writes to it are dropped.
- R10: Each thread fetches exactly once every NUM_THREADS cycles, whatever it executes. An instruction that depends on the one just before it in the same thread still sees that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Fetch byte address (selected thread's PC) |
| imem_rdata | input | 32 | Instruction word for `imem_addr`, same cycle |
| fetch_tid | output | TID_W | Thread being fetched this cycle |
| dmem_addr | output | 32 | Data byte address for load or store |
| dmem_we | output | 1 | Store strobe |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, same cycle |

## Verification
A selector that rotates wrongly shows on `fetch_tid` in the very next cycle. A program counter that was updated wrongly, or written to the wrong thread, shows on `imem_addr` at that thread's next slot, NUM_THREADS cycles later. A write that lands in the wrong register bank, or in register 0, cannot be seen until the thread stores the register. For that reason the bench program stores each intermediate result, and it checks when each thread first reaches its halt loop. Both checks reflect every branch decision and every stall-free cycle.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    localparam int XLEN      = 32;
    localparam int RIDX_W    = 5;
    localparam int ARCH_REGS = 32;

    typedef enum logic [5:0] {
        OPC_NOP   = 6'd0,
        OPC_ADD   = 6'd1,
        OPC_SUB   = 6'd2,
        OPC_AND   = 6'd3,
        OPC_OR    = 6'd4,
        OPC_XOR   = 6'd5,
        OPC_ADDI  = 6'd6,
        OPC_LW    = 6'd7,
        OPC_SW    = 6'd8,
        OPC_BEQZ  = 6'd9,
        OPC_MULLO = 6'd10,
        OPC_MULHI = 6'd11,
        OPC_TID   = 6'd12
    } opcode_e;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_MULLO,
        FN_MULHI,
        FN_TID
    } alu_fn_e;

    typedef struct packed {
        logic              wr_en;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] src_b;
        logic              use_imm;
        logic              is_load;
        logic              is_store;
        logic              is_branch;
        alu_fn_e           fn;
        logic [XLEN-1:0]   imm;
    } dec_t;

endpackage

// File: rtl/mtc_thread_rr.sv
module mtc_thread_rr #(
    parameter int NUM_THREADS = 3,
    parameter int TID_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TID_W-1:0] slot
);

    localparam logic [TID_W-1:0] LAST_SLOT = TID_W'(NUM_THREADS - 1);

    logic [TID_W-1:0] slot_q;
    logic [TID_W-1:0] slot_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    // next slot: advance every cycle, wrap after the last thread
    always_comb begin
        if (slot_q == LAST_SLOT) begin
            slot_d = '0;
        end else begin
            slot_d = slot_q + 1'b1;
        end
    end

    assign slot = slot_q;

endmodule

// File: rtl/mtc_decode.sv
module mtc_decode
    import mtc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);

    opcode_e opc;
    assign opc = opcode_e'(instr[31:26]);

    always_comb begin
        dec       = '0;
        dec.fn    = FN_ADD;
        dec.src_a = instr[25:21];
        dec.src_b = instr[20:16];
        dec.imm   = {{(XLEN-16){instr[15]}}, instr[15:0]};
        unique case (opc)
            OPC_ADD:   begin dec.wr_en = 1'b1; dec.dst = instr[15:11]; dec.fn = FN_ADD;   end
            OPC_SUB:   begin dec.wr_en = 1'b1; dec.dst = instr[15:11]; dec.fn = FN_SUB;   end
            OPC_AND:   begin dec.wr_en = 1'b1; dec.dst = instr[15:11]; dec.fn = FN_AND;   end
            OPC_OR:    begin dec.wr_en = 1'b1; dec.dst = instr[15:11]; dec.fn = FN_OR;    end
            OPC_XOR:   begin dec.wr_en = 1'b1; dec.dst = instr[15:11]; dec.fn = FN_XOR;   end
            OPC_MULLO: begin dec.wr_en = 1'b1; dec.dst = instr[15:11]; dec.fn = FN_MULLO; end
            OPC_MULHI: begin dec.wr_en = 1'b1; dec.dst = instr[15:11]; dec.fn = FN_MULHI; end
            OPC_TID:   begin dec.wr_en = 1'b1; dec.dst = instr[15:11]; dec.fn = FN_TID;   end
            OPC_ADDI: begin
                dec.wr_en   = 1'b1;
                dec.dst     = instr[20:16];
                dec.use_imm = 1'b1;
            end
            OPC_LW: begin
                dec.wr_en   = 1'b1;
                dec.dst     = instr[20:16];
                dec.use_imm = 1'b1;
                dec.is_load = 1'b1;
            end
            OPC_SW: begin
                dec.use_imm  = 1'b1;
                dec.is_store = 1'b1;
            end
            OPC_BEQZ: begin
                dec.is_branch = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/mtc_exec.sv
module mtc_exec
    import mtc_pkg::*;
#(
    parameter int TID_W = 2
) (
    input  alu_fn_e          fn,
    input  logic             use_imm,
    input  logic             is_load,
    input  logic             is_branch,
    input  logic [XLEN-1:0]  imm,
    input  logic [TID_W-1:0] tid,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic [XLEN-1:0]  load_data,
    output logic [XLEN-1:0]  result,
    output logic [XLEN-1:0]  next_pc,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  store_data
);

    logic [XLEN-1:0]   b_eff;
    logic [XLEN-1:0]   alu_out;
    logic [XLEN-1:0]   seq_pc;
    logic [2*XLEN-1:0] product;
    logic              taken;

    assign b_eff      = use_imm ? imm : opb;
    assign product    = {{XLEN{1'b0}}, opa} * {{XLEN{1'b0}}, opb};
    assign mem_addr   = opa + imm;
    assign store_data = opb;
    assign seq_pc     = pc + XLEN'(4);
    assign taken      = is_branch && (opa == '0);
    assign next_pc    = taken ? (seq_pc + {imm[XLEN-3:0], 2'b00}) : seq_pc;

    always_comb begin
        unique case (fn)
            FN_ADD:   alu_out = opa + b_eff;
            FN_SUB:   alu_out = opa - b_eff;
            FN_AND:   alu_out = opa & b_eff;
            FN_OR:    alu_out = opa | b_eff;
            FN_XOR:   alu_out = opa ^ b_eff;
            FN_MULLO: alu_out = product[XLEN-1:0];
            FN_MULHI: alu_out = product[2*XLEN-1:XLEN];
            FN_TID:   alu_out = {{(XLEN-TID_W){1'b0}}, tid};
            default:  alu_out = '0;
        endcase
    end

    assign result = is_load ? load_data : alu_out;

endmodule

// File: rtl/mtc_regbank.sv
module mtc_regbank
    import mtc_pkg::*;
#(
    parameter int NUM_THREADS = 3,
    parameter int TID_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TID_W-1:0]  rd_tid,
    input  logic [RIDX_W-1:0] rd_a_idx,
    input  logic [RIDX_W-1:0] rd_b_idx,
    output logic [XLEN-1:0]   rd_a,
    output logic [XLEN-1:0]   rd_b,
    input  logic              wr_en,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_data
);

    localparam int DEPTH = NUM_THREADS * ARCH_REGS;

    logic [XLEN-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en && (wr_idx != '0)) begin
            mem_q[{wr_tid, wr_idx}] <= wr_data;
        end
    end

    assign rd_a = (rd_a_idx == '0) ? '0 : mem_q[{rd_tid, rd_a_idx}];
    assign rd_b = (rd_b_idx == '0) ? '0 : mem_q[{rd_tid, rd_b_idx}];

endmodule

// File: rtl/mt_core.sv
module mt_core
    import mtc_pkg::*;
#(
    parameter int          NUM_THREADS = 3,
    parameter logic [31:0] RESET_PC    = 32'h0000_0000,
    localparam int         TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [31:0]      imem_addr,
    input  logic [31:0]      imem_rdata,
    output logic [TID_W-1:0] fetch_tid,
    output logic [31:0]      dmem_addr,
    output logic             dmem_we,
    output logic [31:0]      dmem_wdata,
    input  logic [31:0]      dmem_rdata
);

    // ---------------- fetch / decode ----------------
    logic [TID_W-1:0] cur_tid;
    logic [XLEN-1:0]  pc_q [NUM_THREADS];
    logic [XLEN-1:0]  fetch_pc;
    dec_t             dec_f;

    mtc_thread_rr #(
        .NUM_THREADS(NUM_THREADS),
        .TID_W      (TID_W)
    ) u_rr (
        .clk  (clk),
        .rst_n(rst_n),
        .slot (cur_tid)
    );

    assign fetch_pc  = pc_q[cur_tid];
    assign imem_addr = fetch_pc;
    assign fetch_tid = cur_tid;

    mtc_decode u_dec (
        .instr(imem_rdata),
        .dec  (dec_f)
    );

    // ---------------- execute stage registers ----------------
    logic             ex_vld_q;
    logic [TID_W-1:0] ex_tid_q;
    logic [XLEN-1:0]  ex_pc_q;
    dec_t             ex_dec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_vld_q <= 1'b0;
            ex_tid_q <= '0;
            ex_pc_q  <= '0;
            ex_dec_q <= '0;
        end else begin
            ex_vld_q <= 1'b1;
            ex_tid_q <= cur_tid;
            ex_pc_q  <= fetch_pc;
            ex_dec_q <= dec_f;
        end
    end

    // ---------------- register read / execute / memory ----------------
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] ex_result;
    logic [XLEN-1:0] ex_next_pc;
    logic [XLEN-1:0] ex_mem_addr;
    logic [XLEN-1:0] ex_store_data;

    logic             wb_vld_q;
    logic [TID_W-1:0] wb_tid_q;
    logic             wb_we_q;
    logic [RIDX_W-1:0] wb_idx_q;
    logic [XLEN-1:0]  wb_data_q;

    mtc_regbank #(
        .NUM_THREADS(NUM_THREADS),
        .TID_W      (TID_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_tid  (ex_tid_q),
        .rd_a_idx(ex_dec_q.src_a),
        .rd_b_idx(ex_dec_q.src_b),
        .rd_a    (opa),
        .rd_b    (opb),
        .wr_en   (wb_vld_q && wb_we_q),
        .wr_tid  (wb_tid_q),
        .wr_idx  (wb_idx_q),
        .wr_data (wb_data_q)
    );

    mtc_exec #(
        .TID_W(TID_W)
    ) u_exec (
        .fn        (ex_dec_q.fn),
        .use_imm   (ex_dec_q.use_imm),
        .is_load   (ex_dec_q.is_load),
        .is_branch (ex_dec_q.is_branch),
        .imm       (ex_dec_q.imm),
        .tid       (ex_tid_q),
        .pc        (ex_pc_q),
        .opa       (opa),
        .opb       (opb),
        .load_data (dmem_rdata),
        .result    (ex_result),
        .next_pc   (ex_next_pc),
        .mem_addr  (ex_mem_addr),
        .store_data(ex_store_data)
    );

    assign dmem_addr  = ex_mem_addr;
    assign dmem_wdata = ex_store_data;
    assign dmem_we    = ex_vld_q && ex_dec_q.is_store;

    // per-thread program counters, written as the branch resolves
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_THREADS; i++) begin
                pc_q[i] <= RESET_PC;
            end
        end else if (ex_vld_q) begin
            pc_q[ex_tid_q] <= ex_next_pc;
        end
    end

    // ---------------- writeback stage registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_vld_q  <= 1'b0;
            wb_tid_q  <= '0;
            wb_we_q   <= 1'b0;
            wb_idx_q  <= '0;
            wb_data_q <= '0;
        end else begin
            wb_vld_q  <= ex_vld_q;
            wb_tid_q  <= ex_tid_q;
            wb_we_q   <= ex_vld_q && ex_dec_q.wr_en;
            wb_idx_q  <= ex_dec_q.dst;
            wb_data_q <= ex_result;
        end
    end

endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
    parameter int NUM_THREADS = 3,
    parameter int TID_W       = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TID_W-1:0] fetch_tid,
    input logic [31:0]      imem_addr,
    input logic             ex_vld,
    input logic [TID_W-1:0] ex_tid,
    input logic [31:0]      ex_pc,
    input logic             wb_vld,
    input logic [TID_W-1:0] wb_tid
);

    localparam logic [TID_W-1:0] LAST_SLOT = TID_W'(NUM_THREADS - 1);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_TID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_tid <= LAST_SLOT); // R1

    AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1) |-> (fetch_tid == (($past(fetch_tid) == LAST_SLOT) ? '0 : $past(fetch_tid) + 1'b1))); // R1

    AST_PC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[1:0] == 2'b00); // R3

    AST_EX_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1) |-> (ex_vld && ex_tid == $past(fetch_tid) && ex_pc == $past(imem_addr))); // R10

    AST_WB_FOLLOWS_EX: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (wb_vld && wb_tid == $past(ex_tid))); // R8

    AST_DISTINCT_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_vld && wb_vld) |-> (ex_tid != wb_tid)); // R8

endmodule

bind mt_core mtc_checker #(
    .NUM_THREADS(NUM_THREADS),
    .TID_W      (TID_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_tid(fetch_tid),
    .imem_addr(imem_addr),
    .ex_vld   (ex_vld_q),
    .ex_tid   (ex_tid_q),
    .ex_pc    (ex_pc_q),
    .wb_vld   (wb_vld_q),
    .wb_tid   (wb_tid_q)
);

// File: tb/mt_core_tb.sv
module mt_core_tb;

    localparam int NT        = 3;
    localparam int TW        = 2;
    localparam int IWORDS    = 64;
    localparam int DWORDS    = 64;
    localparam int RUN_CYC   = 300;
    localparam int HALT_ADDR = 144;

    localparam logic [5:0] OP_ADD = 6'd1, OP_SUB = 6'd2, OP_AND = 6'd3, OP_OR = 6'd4,
                           OP_XOR = 6'd5, OP_ADDI = 6'd6, OP_LW = 6'd7, OP_SW = 6'd8,
                           OP_BEQZ = 6'd9, OP_MLO = 6'd10, OP_MHI = 6'd11, OP_TID = 6'd12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [31:0]   imem_addr;
    logic [31:0]   imem_rdata;
    logic [TW-1:0] fetch_tid;
    logic [31:0]   dmem_addr;
    logic          dmem_we;
    logic [31:0]   dmem_wdata;
    logic [31:0]   dmem_rdata;

    logic [31:0] imem [IWORDS];
    logic [31:0] dmem [DWORDS];

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    mt_core #(
        .NUM_THREADS(NT),
        .RESET_PC   (32'h0)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_rdata(imem_rdata),
        .fetch_tid (fetch_tid),
        .dmem_addr (dmem_addr),
        .dmem_we   (dmem_we),
        .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata)
    );

    function automatic logic [31:0] enc_r(logic [5:0] op, int rd, int rs, int rt);
        return {op, 5'(rs), 5'(rt), 5'(rd), 11'd0};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rt, int rs, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    int fcount [NT];
    int halt_idx [NT];

    initial begin
        for (int i = 0; i < IWORDS; i++) imem[i] = 32'h0;
        for (int i = 0; i < DWORDS; i++) dmem[i] = 32'hDEAD_0000 | 32'(i);
        imem[0]  = enc_r(OP_TID, 1, 0, 0);
        imem[1]  = enc_i(OP_ADDI, 4, 0, 64);
        imem[2]  = enc_r(OP_MLO, 3, 1, 4);
        imem[3]  = enc_i(OP_SW, 7, 3, 0);
        imem[4]  = enc_i(OP_ADDI, 5, 1, -3);
        imem[5]  = enc_i(OP_ADDI, 6, 1, 1000);
        imem[6]  = enc_r(OP_ADD, 8, 5, 6);
        imem[7]  = enc_r(OP_SUB, 9, 5, 6);
        imem[8]  = enc_r(OP_AND, 10, 6, 8);
        imem[9]  = enc_r(OP_OR, 11, 6, 8);
        imem[10] = enc_r(OP_XOR, 12, 6, 8);
        imem[11] = enc_i(OP_ADDI, 0, 0, 77);
        imem[12] = enc_i(OP_SW, 0, 3, 4);
        imem[13] = enc_i(OP_SW, 8, 3, 8);
        imem[14] = enc_i(OP_SW, 9, 3, 12);
        imem[15] = enc_i(OP_SW, 10, 3, 16);
        imem[16] = enc_i(OP_SW, 11, 3, 20);
        imem[17] = enc_i(OP_SW, 12, 3, 24);
        imem[18] = enc_i(OP_ADDI, 13, 0, -1);
        imem[19] = enc_r(OP_MHI, 14, 13, 13);
        imem[20] = enc_r(OP_MLO, 15, 13, 13);
        imem[21] = enc_i(OP_SW, 14, 3, 28);
        imem[22] = enc_i(OP_SW, 15, 3, 32);
        imem[23] = enc_i(OP_LW, 16, 3, 8);
        imem[24] = enc_i(OP_ADDI, 16, 16, 1);
        imem[25] = enc_i(OP_SW, 16, 3, 36);
        imem[26] = enc_i(OP_ADDI, 17, 1, 2);
        imem[27] = enc_i(OP_ADDI, 18, 0, 0);
        imem[28] = enc_i(OP_BEQZ, 0, 17, 3);
        imem[29] = enc_i(OP_ADDI, 18, 18, 10);
        imem[30] = enc_i(OP_ADDI, 17, 17, -1);
        imem[31] = enc_i(OP_BEQZ, 0, 0, -4);
        imem[32] = enc_i(OP_SW, 18, 3, 40);
        imem[33] = enc_i(OP_BEQZ, 0, 1, 1);
        imem[34] = enc_i(OP_ADDI, 19, 0, 7);
        imem[35] = enc_i(OP_SW, 19, 3, 44);
        imem[36] = enc_i(OP_BEQZ, 0, 0, -1);

        for (int t = 0; t < NT; t++) begin
            fcount[t]   = 0;
            halt_idx[t] = -1;
        end

        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(fetch_tid == '0, "R2 reset fetch_tid", 32'(fetch_tid), 32'h0);
        check(imem_addr == 32'h0, "R2 reset imem_addr", imem_addr, 32'h0);
        check(dmem_we == 1'b0, "R2 reset dmem_we", 32'(dmem_we), 32'h0);
        rst_n = 1'b1;
        #1;

        for (int cyc = 0; cyc < RUN_CYC; cyc++) begin
            automatic int t = cyc % NT;
            automatic int k;
            check(fetch_tid == TW'(t), "R1 round-robin thread", 32'(fetch_tid), 32'(t));
            k = fcount[t];
            if (k == 0) begin
                check(imem_addr == 32'h0, "R2 first fetch at reset PC", imem_addr, 32'h0);
            end else if (k < 28) begin
                check(imem_addr == 32'(4 * k), "R3 sequential fetch", imem_addr, 32'(4 * k));
            end
            if (imem_addr == 32'(HALT_ADDR) && halt_idx[t] < 0) halt_idx[t] = k;
            fcount[t] = k + 1;
            @(negedge clk);
            #1;
        end

        for (int t = 0; t < NT; t++) begin
            automatic int          c    = t + 2;
            automatic int          exp_h = (t == 0) ? 32 + 4 * c : 33 + 4 * c;
            automatic int          base = 16 * t;
            automatic logic [31:0] r5   = 32'(t) - 32'd3;
            automatic logic [31:0] r6   = 32'(t) + 32'd1000;
            automatic logic [31:0] r8   = r5 + r6;
            // R10 and R5: fetch index of halt depends on each branch and no stall
            check(halt_idx[t] == exp_h, "R10 R5 halt fetch index", 32'(halt_idx[t]), 32'(exp_h));
            check(dmem[base + 0] == 32'h0, "R2 untouched register reads zero", dmem[base + 0], 32'h0);
            check(dmem[base + 1] == 32'h0, "R9 r0 write dropped", dmem[base + 1], 32'h0);
            check(dmem[base + 2] == r8, "R4 R8 add per thread", dmem[base + 2], r8);
            check(dmem[base + 3] == r5 - r6, "R4 sub", dmem[base + 3], r5 - r6);
            check(dmem[base + 4] == (r6 & r8), "R4 and", dmem[base + 4], r6 & r8);
            check(dmem[base + 5] == (r6 | r8), "R4 or", dmem[base + 5], r6 | r8);
            check(dmem[base + 6] == (r6 ^ r8), "R4 xor", dmem[base + 6], r6 ^ r8);
            check(dmem[base + 7] == 32'hFFFF_FFFE, "R7 mul high", dmem[base + 7], 32'hFFFF_FFFE);
            check(dmem[base + 8] == 32'h1, "R7 mul low", dmem[base + 8], 32'h1);
            check(dmem[base + 9] == r8 + 32'd1, "R6 load then add", dmem[base + 9], r8 + 32'd1);
            check(dmem[base + 10] == 32'(10 * c), "R5 loop count", dmem[base + 10], 32'(10 * c));
            check(dmem[base + 11] == ((t == 0) ? 32'h0 : 32'h7), "R5 R8 skip on zero tid",
                  dmem[base + 11], (t == 0) ? 32'h0 : 32'h7);
            for (int w = 12; w < 16; w++) begin
                check(dmem[base + w] == (32'hDEAD_0000 | 32'(base + w)), "R6 no stray store",
                      dmem[base + w], 32'hDEAD_0000 | 32'(base + w));
            end
        end
        for (int w = 16 * NT; w < DWORDS; w++) begin
            check(dmem[w] == (32'hDEAD_0000 | 32'(w)), "R6 no store outside thread areas",
                  dmem[w], 32'hDEAD_0000 | 32'(w));
        end
        finish_run();
    end

endmodule